// File: doc/BRIEF.md
# USB Host Transaction Error Tracker

This block watches a single host-side transaction phase and keeps the retry budget of the transfer descriptor that phase belongs to. When the host finishes sending its end-of-packet, a turnaround timer starts counting bit-time ticks. If no start-of-packet arrives from the device within the allowed number of bit times, the block reports a bus timeout. At the end of every packet received from the device, it looks at the CRC checker's verdict and at the receive-buffer overrun flag. From these it decides whether the host acknowledges IN data.

A CRC failure and a timeout are treated as the same class of failure. Each one consumes one unit of a small per-descriptor error budget. The budget is loaded when the descriptor starts. When it runs out, the descriptor is flagged halted and a one-cycle error event is raised. A budget loaded as zero means the retries never run out. Line signalling and writing status back to memory belong to other blocks.

Top module: `usb_txn_err_tracker`

## Requirements
- R1: After reset, `send_ack`, `bus_timeout`, `desc_halted` and `err_event` are 0 and `err_count` is 0.
- R2: After `host_eop_end`, the 19th `bit_tick` with no `dev_sop` seen raises `bus_timeout` in the next cycle. `bus_timeout` is a one-cycle pulse, and the timer is then idle.
- R3: A `dev_sop` on or before the 19th tick stops the timer, so no `bus_timeout` follows however many further ticks arrive.
- R4: A new `host_eop_end` restarts the count from zero. A tick in the same cycle as `host_eop_end` is not counted.
- R5: Ticks while no turnaround is being timed have no effect, so no `bus_timeout` is raised.
- R6: A `dev_pkt_end` with `dir_in`=1, `rx_crc_bad`=0 and `rx_overrun`=0 gives a one-cycle `send_ack` in the next cycle.
- R7: When the data is corrupted (`rx_crc_bad`=1), overrun (`rx_overrun`=1), or the phase is not IN (`dir_in`=0), no `send_ack` is given. ACK is the only handshake the block ever requests.
- R8: A `dev_pkt_end` with `rx_crc_bad`=1 decrements `err_count` by one in the next cycle.
- R9: A `bus_timeout` pulse decrements `err_count` by one in the cycle after the pulse.
- R10: When `err_count_init` is loaded as 0, `err_count` stays 0 and neither `desc_halted` nor `err_event` is ever raised.
- R11: The failure that takes `err_count` from 1 to 0 sets `desc_halted` and a one-cycle `err_event` in the same cycle. `desc_halted` then holds, and later failures leave `err_count` unchanged.
- R12: A packet end without a CRC error, including one with only an overrun, leaves `err_count` unchanged.
- R13: `desc_start` loads `err_count_init` into `err_count` and clears `desc_halted` in the next cycle. It takes priority over a failure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_start | input | 1 | Descriptor start strobe, loads the error budget |
| err_count_init | input | 2 | Error budget from the descriptor (0 = unlimited) |
| host_eop_end | input | 1 | Strobe: host end-of-packet finished, start turnaround timing |
| bit_tick | input | 1 | One pulse per bit time |
| dev_sop | input | 1 | Start-of-packet detected from the device |
| dev_pkt_end | input | 1 | Strobe: device packet fully received |
| dir_in | input | 1 | Current phase is IN data |
| rx_crc_bad | input | 1 | CRC checker verdict for the ending packet |
| rx_overrun | input | 1 | Receive buffer could not take the data |
| send_ack | output | 1 | Pulse: host must send ACK |
| bus_timeout | output | 1 | Pulse: turnaround timeout |
| err_count | output | 2 | Current error budget |
| desc_halted | output | 1 | Descriptor halted, budget exhausted |
| err_event | output | 1 | Pulse: budget just ran out |

## Verification
`send_ack`, and for a CRC failure the new `err_count`, are due one cycle after the `dev_pkt_end` strobe. `bus_timeout` is due one cycle after the 19th tick. The decrement it causes, together with `desc_halted` and `err_event`, is due one cycle after that. The bench drives each strobe on a falling edge and removes it on the next falling edge, where it then samples exactly that cycle's results. It samples once more a cycle later to confirm that the pulses have ended. A reference budget held in the bench, updated by its own function, gives the expected count for both directed corner cases and random sequences.

// File: rtl/usb_tet_pkg.sv
package usb_tet_pkg;
  localparam int TMO_BITS = 19;
  localparam int CERR_W   = 2;

  typedef logic [CERR_W-1:0] cerr_t;

  // budget after one failure
  function automatic cerr_t cerr_dec(input cerr_t c);
    return c - cerr_t'(1);
  endfunction

  // this failure uses the last unit of the budget
  function automatic logic cerr_last(input cerr_t c);
    return c == cerr_t'(1);
  endfunction

  // host acknowledges only clean, accepted IN data
  function automatic logic ack_ok(input logic is_in, input logic crc_bad, input logic ovr);
    return is_in && !crc_bad && !ovr;
  endfunction
endpackage

// File: rtl/usb_tet_turnaround.sv
module usb_tet_turnaround #(
  parameter int LIMIT = usb_tet_pkg::TMO_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic sop,
  output logic tmo_pulse,
  output logic armed_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          tmo_q;
  logic          at_limit;

  assign at_limit = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      if (start) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && sop) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (at_limit) begin
          armed <= 1'b0;
          tmo_q <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign tmo_pulse = tmo_q;
  assign armed_o   = armed;
endmodule

// File: rtl/usb_tet_handshake.sv
module usb_tet_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_end,
  input  logic is_in,
  input  logic crc_bad,
  input  logic ovr,
  output logic ack_pulse,
  output logic crc_evt
);
  import usb_tet_pkg::*;

  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= pkt_end && ack_ok(is_in, crc_bad, ovr);
  end

  assign ack_pulse = ack_q;
  assign crc_evt   = pkt_end && crc_bad;
endmodule

// File: rtl/usb_tet_budget.sv
module usb_tet_budget
  import usb_tet_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  cerr_t load_val,
  input  logic  fail,
  output cerr_t cnt_o,
  output logic  halt_o,
  output logic  irq_o,
  output logic  unlim_o
);
  cerr_t cnt;
  logic  halt, irq, unlim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      halt  <= 1'b0;
      irq   <= 1'b0;
      unlim <= 1'b1;
    end else begin
      irq <= 1'b0;
      if (load) begin
        cnt   <= load_val;
        unlim <= (load_val == '0);
        halt  <= 1'b0;
      end else if (fail && !unlim && !halt) begin
        cnt <= cerr_dec(cnt);
        if (cerr_last(cnt)) begin
          halt <= 1'b1;
          irq  <= 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt;
  assign halt_o  = halt;
  assign irq_o   = irq;
  assign unlim_o = unlim;
endmodule

// File: rtl/usb_txn_err_tracker.sv
module usb_txn_err_tracker
  import usb_tet_pkg::*;
#(
  parameter int LIMIT = TMO_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_start,
  input  logic [CERR_W-1:0] err_count_init,
  input  logic              host_eop_end,
  input  logic              bit_tick,
  input  logic              dev_sop,
  input  logic              dev_pkt_end,
  input  logic              dir_in,
  input  logic              rx_crc_bad,
  input  logic              rx_overrun,
  output logic              send_ack,
  output logic              bus_timeout,
  output logic [CERR_W-1:0] err_count,
  output logic              desc_halted,
  output logic              err_event
);
  // internal events, named for the checker
  logic tmo_evt;
  logic crc_evt;
  logic fail_evt;
  logic unlim;
  logic tmr_armed;

  usb_tet_turnaround #(.LIMIT(LIMIT)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (host_eop_end),
    .tick      (bit_tick),
    .sop       (dev_sop),
    .tmo_pulse (tmo_evt),
    .armed_o   (tmr_armed)
  );

  usb_tet_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_end   (dev_pkt_end),
    .is_in     (dir_in),
    .crc_bad   (rx_crc_bad),
    .ovr       (rx_overrun),
    .ack_pulse (send_ack),
    .crc_evt   (crc_evt)
  );

  assign fail_evt = crc_evt || tmo_evt;

  usb_tet_budget u_bud (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (desc_start),
    .load_val (err_count_init),
    .fail     (fail_evt),
    .cnt_o    (err_count),
    .halt_o   (desc_halted),
    .irq_o    (err_event),
    .unlim_o  (unlim)
  );

  assign bus_timeout = tmo_evt;
endmodule

// File: rtl/usb_txn_err_tracker_chk.sv
module usb_txn_err_tracker_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_start,
  input logic          dev_pkt_end,
  input logic          dir_in,
  input logic          rx_crc_bad,
  input logic          rx_overrun,
  input logic          send_ack,
  input logic          bus_timeout,
  input logic [CW-1:0] err_count,
  input logic          desc_halted,
  input logic          err_event,
  input logic          fail_evt,
  input logic          unlim,
  input logic          tmr_armed
);
  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |=> !bus_timeout); // R2
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |-> !tmr_armed || $past(tmr_armed)); // R2
  AST_ACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    send_ack |-> $past(dev_pkt_end && dir_in && !rx_crc_bad && !rx_overrun)); // R6
  AST_NO_ACK_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pkt_end && (rx_crc_bad || rx_overrun || !dir_in)) |=> !send_ack); // R7
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && !desc_start && !unlim && !desc_halted) |=> ((err_count + 1'b1) == $past(err_count))); // R8
  AST_UNLIM_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    unlim |-> !desc_halted); // R10
  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_halted |-> (err_count == '0)); // R11
  AST_IRQ_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> desc_halted && !$past(desc_halted)); // R11
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_evt && !desc_start) |=> $stable(err_count)); // R12
endmodule

bind usb_txn_err_tracker usb_txn_err_tracker_chk #(.CW(usb_tet_pkg::CERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .desc_start  (desc_start),
  .dev_pkt_end (dev_pkt_end),
  .dir_in      (dir_in),
  .rx_crc_bad  (rx_crc_bad),
  .rx_overrun  (rx_overrun),
  .send_ack    (send_ack),
  .bus_timeout (bus_timeout),
  .err_count   (err_count),
  .desc_halted (desc_halted),
  .err_event   (err_event),
  .fail_evt    (fail_evt),
  .unlim       (unlim),
  .tmr_armed   (tmr_armed)
);

// File: tb/usb_txn_err_tracker_bench.sv
module usb_txn_err_tracker_bench;
  localparam int LIM = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       desc_start = 1'b0;
  logic [1:0] err_count_init = 2'd0;
  logic       host_eop_end = 1'b0;
  logic       bit_tick = 1'b0;
  logic       dev_sop = 1'b0;
  logic       dev_pkt_end = 1'b0;
  logic       dir_in = 1'b0;
  logic       rx_crc_bad = 1'b0;
  logic       rx_overrun = 1'b0;
  logic       send_ack, bus_timeout, desc_halted, err_event;
  logic [1:0] err_count;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference budget
  int m_cnt = 0;
  bit m_unlim = 1'b1;
  bit m_halt = 1'b0;
  bit m_irq = 1'b0;

  always #10 clk = ~clk;

  usb_txn_err_tracker u_usb_txn_err_tracker (
    .clk(clk), .rst_n(rst_n), .desc_start(desc_start), .err_count_init(err_count_init),
    .host_eop_end(host_eop_end), .bit_tick(bit_tick), .dev_sop(dev_sop),
    .dev_pkt_end(dev_pkt_end), .dir_in(dir_in), .rx_crc_bad(rx_crc_bad),
    .rx_overrun(rx_overrun), .send_ack(send_ack), .bus_timeout(bus_timeout),
    .err_count(err_count), .desc_halted(desc_halted), .err_event(err_event)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected budget after one failure
  function automatic int next_cnt(input int c, input bit unl, input bit hlt);
    if (unl || hlt) return c;
    return c - 1;
  endfunction

  task automatic model_fail();
    int n;
    n = next_cnt(m_cnt, m_unlim, m_halt);
    m_irq = (n == 0) && (m_cnt == 1) && !m_unlim && !m_halt;
    if (m_irq) m_halt = 1'b1;
    m_cnt = n;
  endtask

  task automatic check_budget(input string req);
    check({req, " count"}, err_count, m_cnt);
    check({req, " halted"}, desc_halted, m_halt);
    check({req, " event"}, err_event, m_irq);
  endtask

  task automatic load(input int v);
    @(negedge clk);
    desc_start = 1'b1; err_count_init = 2'(v);
    @(negedge clk);
    desc_start = 1'b0;
    m_cnt = v; m_unlim = (v == 0); m_halt = 1'b0; m_irq = 1'b0;
    check_budget("R13 load");
  endtask

  task automatic pkt(input bit in_d, input bit crc, input bit ovr);
    @(negedge clk);
    dev_pkt_end = 1'b1; dir_in = in_d; rx_crc_bad = crc; rx_overrun = ovr;
    @(negedge clk);
    dev_pkt_end = 1'b0; dir_in = 1'b0; rx_crc_bad = 1'b0; rx_overrun = 1'b0;
    check("R6/R7 ack", send_ack, int'(in_d && !crc && !ovr));
    m_irq = 1'b0;
    if (crc) begin
      model_fail();
      check_budget("R8/R11 crc");
    end else begin
      check_budget("R12 clean");
    end
    @(negedge clk);
    check("R6 ack pulse", send_ack, 0);
    check("R11 event pulse", err_event, 0);
  endtask

  // sop_at: tick index on which the device answers; >LIM means never
  task automatic turn(input int sop_at);
    bit exp_t;
    @(negedge clk);
    host_eop_end = 1'b1;
    bit_tick = 1'b1;            // R4: not counted
    @(negedge clk);
    host_eop_end = 1'b0; bit_tick = 1'b0;
    for (int i = 1; i <= LIM + 3; i++) begin
      bit_tick = 1'b1; dev_sop = (i == sop_at);
      @(negedge clk);
      bit_tick = 1'b0; dev_sop = 1'b0;
      exp_t = (sop_at > LIM) && (i == LIM);
      check(sop_at > LIM ? "R2 timeout" : "R3 answered", bus_timeout, int'(exp_t));
      m_irq = 1'b0;
      @(negedge clk);
      if (exp_t) begin
        check("R2 one-cycle", bus_timeout, 0);
        model_fail();
        check_budget("R9 timeout");
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 ack", send_ack, 0);
    check("R1 timeout", bus_timeout, 0);
    check("R1 count", err_count, 0);
    check("R1 halted", desc_halted, 0);
    check("R1 event", err_event, 0);
    rst_n = 1'b1;

    // R5: ticks with no EOP
    for (int i = 0; i < LIM + 5; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      check("R5 idle tick", bus_timeout, 0);
    end

    load(3);
    turn(LIM + 1);                 // R2, R9
    turn(LIM);                     // R3 boundary
    turn(1);
    pkt(1, 0, 0);                  // R6
    pkt(1, 0, 1);                  // R7, R12
    pkt(0, 0, 0);                  // R7
    pkt(1, 1, 0);                  // R8 -> 1
    pkt(0, 1, 0);                  // R11 -> 0
    pkt(1, 1, 0);                  // R11 sticky
    turn(LIM + 1);                 // R11 sticky

    // R4: restart mid count
    @(negedge clk); host_eop_end = 1'b1;
    @(negedge clk); host_eop_end = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    load(2);
    turn(LIM + 1);                 // fresh 19 count after new EOP

    // R10 unlimited
    load(0);
    for (int i = 0; i < 6; i++) pkt(1, 1, 0);
    turn(LIM + 1);
    check("R10 count", err_count, 0);

    // R13: load wins over same-cycle failure
    load(1);
    @(negedge clk);
    desc_start = 1'b1; err_count_init = 2'd3; dev_pkt_end = 1'b1; rx_crc_bad = 1'b1;
    @(negedge clk);
    desc_start = 1'b0; dev_pkt_end = 1'b0; rx_crc_bad = 1'b0;
    m_cnt = 3; m_unlim = 1'b0; m_halt = 1'b0; m_irq = 1'b0;
    check_budget("R13 priority");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) load(int'($urandom_range(0, 3)));
      else if (op < 6) pkt(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
      else turn(int'($urandom_range(1, LIM + 4)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule